// File: doc/BRIEF.md
# Multi-Mode Programmable Counter Channel

This block is a single channel of an interval timer. It holds a start value N (1 to 65536), counts enabled ticks from the moment that value is accepted, and drives a registered output line. The line follows one of six waveform behaviours: a level that goes high at terminal count, a retriggerable window, a divide-by-N rate pulse, a square wave that also works for odd N, and two single-tick strobes. A live count value is always presented for readback, and its form depends on the behaviour selected.

A new start value and behaviour code arrive together on a valid/ready load port. The channel never applies back-pressure: `load_ready` is held high, so every cycle with `load_valid` high is an accepted load. A load, or a rising edge on the gate in the behaviours that retrigger, restarts counting. This restart takes precedence over a tick in the same cycle. When neither happens, a cycle with `tick` high advances the count by one elapsed tick. The gate has no other effect.

Top module: `ctc_channel`

## Requirements
- R1: After reset the channel uses behaviour 3 with N = 65536. `out` is 1 and `count` is 0.
- R2: A load (`load_valid` high) restarts counting with elapsed ticks d = 0, and it wins over a tick in the same cycle. A `load_count` of 0 means N = 65536. The cycle after a load, `count` equals `load_count`.
- R3: Behaviour 0 (`load_mode` = 0): `out` is 0 while d < N and 1 once d >= N.
- R4: Behaviour 1: `out` is 1 while d < N and 0 once d >= N.
- R5: Behaviour 2: `out` is 1 only when d is a nonzero multiple of N. `count` reads N - (d mod N), modulo 65536.
- R6: Behaviour 3: `out` is 1 when (d mod N) < (N+1)/2 (integer division) and 0 otherwise. `count` reads N - ((2·d) mod N), modulo 65536.
- R7: Behaviours 4 and 5: `out` is 1 only when d equals N.
- R8: In behaviours 1, 2, 3 and 5, a rising edge of `gate` (1 in this cycle, 0 in the previous one) restarts counting with d = 0. In behaviours 0 and 4 a gate edge changes neither `out` nor `count`.
- R9: In behaviours 0, 1, 4 and 5, `count` reads (N - d) mod 65536. It therefore falls by one on each tick and wraps from 0 to 65535.
- R10: Codes 6 and 7 behave exactly like codes 2 and 3.
- R11: In a cycle with no tick and no restart, `out` and `count` keep their values.
- R12: `load_ready` is 1 in every cycle out of reset. A load is taken in every cycle with `load_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable: one elapsed tick per cycle when high |
| gate | input | 1 | Gate level; its rising edge may retrigger |
| load_valid | input | 1 | Load request for a new start value and behaviour |
| load_ready | output | 1 | Load accepted (always 1) |
| load_mode | input | 3 | Behaviour code 0..7 |
| load_count | input | 16 | Start value, 0 meaning 65536 |
| out | output | 1 | Registered output line |
| count | output | 16 | Live count value for readback |

## Verification
Some properties can be checked on every cycle, and the assertions cover these: the count follows the loaded value, the count steps down by one in the linear behaviours, the output and count hold when nothing happens, strobes last a single tick, and the first output level after a load is correct for behaviours 0, 1 and 3. Other properties need a sequence of ticks and can only be shown by the bench scenarios. These are the full waveform shape over several periods, the asymmetric square wave for odd N, the rate pulse with N = 1, gate retriggering compared with gate being ignored, the alias codes, and the wrap of a zero start value through 65536.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  typedef enum logic [2:0] {
    CM_TERM_HIGH  = 3'd0,
    CM_WINDOW     = 3'd1,
    CM_RATE       = 3'd2,
    CM_SQUARE     = 3'd3,
    CM_SOFT_STB   = 3'd4,
    CM_GATE_STB   = 3'd5,
    CM_RATE_ALT   = 3'd6,
    CM_SQUARE_ALT = 3'd7
  } ctc_mode_e;

  // fold the two alias codes onto the behaviour they copy
  function automatic ctc_mode_e fold_mode(input logic [2:0] code);
    case (code)
      3'd6:    return CM_RATE;
      3'd7:    return CM_SQUARE;
      default: return ctc_mode_e'(code);
    endcase
  endfunction

  function automatic logic gate_retriggers(input ctc_mode_e m);
    return (m == CM_WINDOW) || (m == CM_RATE) || (m == CM_SQUARE) ||
           (m == CM_GATE_STB);
  endfunction

endpackage

// File: rtl/ctc_cfg.sv
module ctc_cfg
  import ctc_pkg::*;
#(
  parameter int  CNT_W    = 16,
  parameter bit  GATE_RST = 1'b1,
  localparam int LEN_W    = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic             load_fire,
  input  logic [2:0]       load_mode,
  input  logic [CNT_W-1:0] load_count,
  output logic [LEN_W-1:0] len_q,
  output logic [2:0]       mode_q,
  output logic             restart
);

  localparam logic [LEN_W-1:0] FULL_LEN = {1'b1, {CNT_W{1'b0}}};

  logic gate_q;
  logic gate_rise;

  assign gate_rise = gate & ~gate_q;
  assign restart   = load_fire | (gate_rise & gate_retriggers(fold_mode(mode_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= FULL_LEN;
      mode_q <= 3'd3;
      gate_q <= GATE_RST;
    end else begin
      gate_q <= gate;
      if (load_fire) begin
        len_q  <= (load_count == '0) ? FULL_LEN : {1'b0, load_count};
        mode_q <= load_mode;
      end
    end
  end

endmodule

// File: rtl/ctc_track.sv
module ctc_track #(
  parameter int  CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] load_len,
  output logic [LEN_W-1:0] el_nx,
  output logic [LEN_W-1:0] ph_nx,
  output logic [LEN_W-1:0] ph_q,
  output logic [LEN_W-1:0] ph2_q,
  output logic [CNT_W-1:0] lin_q
);

  logic [LEN_W-1:0] el_q;
  logic [LEN_W-1:0] ph2_nx;
  logic [CNT_W-1:0] lin_nx;
  logic [LEN_W-1:0] el_cap;
  logic [LEN_W:0]   dbl_a;
  logic [LEN_W:0]   dbl_b;
  logic [LEN_W:0]   len_x;

  assign el_cap = len + 1'b1;
  assign len_x  = {1'b0, len};

  always_comb begin
    dbl_a = {1'b0, ph2_q} + 2'd2;
    if (dbl_a >= len_x) dbl_a = dbl_a - len_x;
    dbl_b = dbl_a;
    if (dbl_b >= len_x) dbl_b = dbl_b - len_x;
  end

  always_comb begin
    el_nx  = el_q;
    ph_nx  = ph_q;
    ph2_nx = ph2_q;
    lin_nx = lin_q;
    if (restart) begin
      el_nx  = '0;
      ph_nx  = '0;
      ph2_nx = '0;
      lin_nx = load_len[CNT_W-1:0];
    end else if (tick) begin
      el_nx  = (el_q == el_cap) ? el_q : el_q + 1'b1;
      ph_nx  = (ph_q + 1'b1 == len) ? '0 : ph_q + 1'b1;
      ph2_nx = dbl_b[LEN_W-1:0];
      lin_nx = lin_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      el_q  <= '0;
      ph_q  <= '0;
      ph2_q <= '0;
      lin_q <= '0;
    end else begin
      el_q  <= el_nx;
      ph_q  <= ph_nx;
      ph2_q <= ph2_nx;
      lin_q <= lin_nx;
    end
  end

endmodule

// File: rtl/ctc_wave.sv
module ctc_wave
  import ctc_pkg::*;
#(
  parameter int  CNT_W = 16,
  localparam int LEN_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  ctc_mode_e        mode,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] el_nx,
  input  logic [LEN_W-1:0] ph_nx,
  output logic             out_q
);

  logic [LEN_W:0] half;
  logic           lvl_nx;

  assign half = ({1'b0, len} + 1'b1) >> 1;

  always_comb begin
    case (mode)
      CM_TERM_HIGH:           lvl_nx = (el_nx >= len);
      CM_WINDOW:              lvl_nx = (el_nx < len);
      CM_RATE:                lvl_nx = (ph_nx == '0) && (el_nx != '0);
      CM_SQUARE:              lvl_nx = ({1'b0, ph_nx} < half);
      CM_SOFT_STB,
      CM_GATE_STB:            lvl_nx = (el_nx == len);
      default:                lvl_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       out_q <= 1'b1;
    else if (advance) out_q <= lvl_nx;
  end

endmodule

// File: rtl/ctc_channel.sv
module ctc_channel
  import ctc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit GATE_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [2:0]       load_mode,
  input  logic [CNT_W-1:0] load_count,
  output logic             out,
  output logic [CNT_W-1:0] count
);

  localparam int LEN_W = CNT_W + 1;
  localparam logic [LEN_W-1:0] FULL_LEN = {1'b1, {CNT_W{1'b0}}};

  logic             load_fire;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       mode_q;
  logic             restart;
  logic [LEN_W-1:0] load_len;
  logic [LEN_W-1:0] len_eff;
  ctc_mode_e        mode_eff;
  logic [LEN_W-1:0] el_nx;
  logic [LEN_W-1:0] ph_nx;
  logic [LEN_W-1:0] ph_q;
  logic [LEN_W-1:0] ph2_q;
  logic [CNT_W-1:0] lin_q;
  logic [LEN_W-1:0] rate_left;
  logic [LEN_W-1:0] sq_left;

  assign load_ready = 1'b1;
  assign load_fire  = load_valid & load_ready;

  ctc_cfg #(.CNT_W(CNT_W), .GATE_RST(GATE_RST)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate       (gate),
    .load_fire  (load_fire),
    .load_mode  (load_mode),
    .load_count (load_count),
    .len_q      (len_q),
    .mode_q     (mode_q),
    .restart    (restart)
  );

  // the value and behaviour used from the restart onwards
  assign load_len = (load_count == '0) ? FULL_LEN : {1'b0, load_count};
  assign len_eff  = load_fire ? load_len : len_q;
  assign mode_eff = load_fire ? fold_mode(load_mode) : fold_mode(mode_q);

  ctc_track #(.CNT_W(CNT_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .tick     (tick),
    .len      (len_eff),
    .load_len (len_eff),
    .el_nx    (el_nx),
    .ph_nx    (ph_nx),
    .ph_q     (ph_q),
    .ph2_q    (ph2_q),
    .lin_q    (lin_q)
  );

  ctc_wave #(.CNT_W(CNT_W)) u_wave (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (restart | tick),
    .mode    (mode_eff),
    .len     (len_eff),
    .el_nx   (el_nx),
    .ph_nx   (ph_nx),
    .out_q   (out)
  );

  assign rate_left = len_q - ph_q;
  assign sq_left   = len_q - ph2_q;

  always_comb begin
    case (fold_mode(mode_q))
      CM_RATE:   count = rate_left[CNT_W-1:0];
      CM_SQUARE: count = sq_left[CNT_W-1:0];
      default:   count = lin_q;
    endcase
  end

endmodule

// File: rtl/ctc_channel_chk.sv
module ctc_channel_chk
  import ctc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit GATE_RST = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             gate,
  input logic             load_valid,
  input logic             load_ready,
  input logic [2:0]       load_mode,
  input logic [CNT_W-1:0] load_count,
  input logic             out,
  input logic [CNT_W-1:0] count,
  input logic [2:0]       mode_q
);

  logic      g_seen;
  logic      g_rise;
  ctc_mode_e cur;
  logic      linear;

  always_ff @(posedge clk) begin
    if (!rst_n) g_seen <= GATE_RST;
    else        g_seen <= gate;
  end

  assign g_rise = gate & ~g_seen;
  assign cur    = fold_mode(mode_q);
  assign linear = (cur == CM_TERM_HIGH) || (cur == CM_WINDOW) ||
                  (cur == CM_SOFT_STB)  || (cur == CM_GATE_STB);

  p_load_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> count == $past(load_count));

  p_term_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_mode == 3'd0) |=> !out);

  p_window_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_mode == 3'd1) |=> out);

  p_square_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && fold_mode(load_mode) == CM_SQUARE) |=> out);

  p_strobe_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur == CM_SOFT_STB || cur == CM_GATE_STB) && out && tick &&
     !load_valid && !g_rise) |=> !out);

  p_step_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (linear && tick && !load_valid && !g_rise) |=>
      count == $past(count) - 1'b1);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_valid && !g_rise) |=> ($stable(out) && $stable(count)));

  p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> load_ready);

endmodule

bind ctc_channel ctc_channel_chk #(.CNT_W(CNT_W), .GATE_RST(GATE_RST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .gate       (gate),
  .load_valid (load_valid),
  .load_ready (load_ready),
  .load_mode  (load_mode),
  .load_count (load_count),
  .out        (out),
  .count      (count),
  .mode_q     (mode_q)
);

// File: tb/tb_ctc_channel.sv
module tb_ctc_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        gate = 1'b1;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [2:0]  load_mode = 3'd0;
  logic [15:0] load_count = 16'd0;
  logic        out;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit    o;
    int    c;
    string tag;
  } exp_t;

  exp_t sb[$];

  // reference state
  int  m_len  = 65536;
  int  m_mode = 3;
  int  m_d    = 0;
  bit  m_gp   = 1'b1;

  always #10 clk = ~clk;

  ctc_channel dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
    .load_valid(load_valid), .load_ready(load_ready),
    .load_mode(load_mode), .load_count(load_count),
    .out(out), .count(count)
  );

  function automatic int fold(int m);
    if (m == 6) return 2;
    if (m == 7) return 3;
    return m;
  endfunction

  function automatic bit ref_out(int m, int n, int d);
    case (fold(m))
      0: return d >= n;
      1: return d < n;
      2: return (d % n == 0) && d != 0;
      3: return (d % n) < ((n + 1) / 2);
      default: return d == n;
    endcase
  endfunction

  function automatic int ref_cnt(int m, int n, int d);
    case (fold(m))
      2: return (n - (d % n)) & 16'hffff;
      3: return (n - ((2 * d) % n)) & 16'hffff;
      default: return (n - d) & 16'hffff;
    endcase
  endfunction

  task automatic step(bit tk, bit g, bit ld, int md, int val, string tag);
    exp_t e;
    int   fm;
    @(negedge clk);
    tick = tk; gate = g; load_valid = ld;
    load_mode = 3'(md); load_count = 16'(val);
    fm = fold(m_mode);
    if (ld) begin
      m_len = (val == 0) ? 65536 : val;
      m_mode = md;
      m_d = 0;
    end else if (g && !m_gp && (fm == 1 || fm == 2 || fm == 3 || fm == 5)) begin
      m_d = 0;
    end else if (tk) begin
      m_d++;
    end
    m_gp = g;
    e.o = ref_out(m_mode, m_len, m_d);
    e.c = ref_cnt(m_mode, m_len, m_d);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic run(int n, bit g, string tag);
    for (int i = 0; i < n; i++) step(1'b1, g, 1'b0, 0, 0, tag);
  endtask

  task automatic idle(int n, bit g, string tag);
    for (int i = 0; i < n; i++) step(1'b0, g, 1'b0, 0, 0, tag);
  endtask

  task automatic load(int md, int val, bit g, string tag);
    step(1'b0, g, 1'b1, md, val, tag);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (out !== e.o || int'(count) != e.c) begin
        errors++;
        $display("FAIL %s: out=%0b count=%0d expected out=%0b count=%0d",
                 e.tag, out, count, e.o, e.c);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (out !== 1'b1 || count !== 16'd0 || load_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: out=%0b count=%0d ready=%0b expected out=1 count=0 ready=1",
               out, count, load_ready);
    end
    // R1 / R6: reset behaviour is the square wave over 65536
    run(3, 1'b1, "R1");
    // R3 and R9: terminal count level, then wrap of the readback
    load(0, 3, 1'b1, "R2");
    run(5, 1'b1, "R3");
    idle(3, 1'b1, "R11");
    run(2, 1'b1, "R9");
    // R8: gate edge ignored in behaviour 0
    step(1'b0, 1'b0, 1'b0, 0, 0, "R8");
    step(1'b0, 1'b1, 1'b0, 0, 0, "R8");
    // R4 and R8: window with retrigger
    load(1, 2, 1'b1, "R4");
    run(3, 1'b1, "R4");
    step(1'b1, 1'b0, 1'b0, 0, 0, "R4");
    step(1'b0, 1'b1, 1'b0, 0, 0, "R8");
    run(3, 1'b1, "R8");
    // R5: rate pulse, retriggered by gate
    load(2, 3, 1'b1, "R5");
    run(8, 1'b1, "R5");
    idle(1, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b0, 0, 0, "R8");
    run(4, 1'b1, "R5");
    load(2, 1, 1'b1, "R5");
    run(3, 1'b1, "R5");
    // R6: odd and even square wave, N = 1
    load(3, 5, 1'b1, "R6");
    run(12, 1'b1, "R6");
    load(3, 4, 1'b1, "R6");
    run(9, 1'b1, "R6");
    load(3, 1, 1'b1, "R6");
    run(3, 1'b1, "R6");
    // R7: software strobe ignores gate, hardware strobe retriggers
    load(4, 2, 1'b1, "R7");
    run(2, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b0, 0, 0, "R7");
    step(1'b1, 1'b1, 1'b0, 0, 0, "R8");
    run(2, 1'b1, "R7");
    load(5, 3, 1'b1, "R7");
    run(2, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b0, 0, 0, "R7");
    step(1'b0, 1'b1, 1'b0, 0, 0, "R8");
    run(5, 1'b1, "R7");
    // R10: alias codes
    load(6, 3, 1'b1, "R10");
    run(7, 1'b1, "R10");
    load(7, 3, 1'b1, "R10");
    run(7, 1'b1, "R10");
    // R2: zero means 65536, and load beats a tick in the same cycle
    load(0, 0, 1'b1, "R2");
    run(2, 1'b1, "R2");
    step(1'b1, 1'b1, 1'b1, 1, 4, "R2");
    run(5, 1'b1, "R2");
    @(negedge clk);
    tick = 1'b0; load_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule